// File: doc/BRIEF.md
# Partitioned 8b/10b Line Encoder

This block turns one byte, together with a control flag, into a 10-bit code group that keeps the line DC-balanced and limits runs. Each byte is written HGF EDCBA. The low five bits (x = EDCBA) and the high three bits (y = HGF) go through separate 5b/6b and 3b/4b paths. A character is named Dx.y for data and Kx.y for control. Each path first classifies its input and produces a primary form: the form used when the running disparity is negative, which never carries more zeros than ones. A complementation stage then inverts that form when the running disparity is positive and the sub-block is one that alternates. The running disparity left by the 6-bit sub-block is the disparity the 4-bit sub-block sees.

The running disparity is held in a two-state machine. RD_NEG is the reset state and RD_POS is the other state. On every accepted byte the machine takes the FLIP transition when the full code group carries an unequal count of ones and zeros, and the HOLD transition otherwise. The code group is registered and appears one clock after the load strobe, with a valid qualifier and the new disparity. A control flag raised on a byte that is not one of the twelve legal control characters raises an error flag. The byte is then encoded as the data character with the same value.

Top module: `line_enc8b10b`

## Requirements
- R1: While reset is asserted, and after it is released, the running disparity output is 0 (negative) and the code-valid output is 0.
- R2: A byte loaded with in_vld=1 on a rising edge appears on code_o with code_vld_o=1 after that same edge, so there is one cycle of latency. code_vld_o is 0 in cycles with no load.
- R3: code_o = {a,b,c,d,e,i,f,g,h,j}, with code_o[9] = a sent first. The bits [9:4] carry the 6-bit sub-block of EDCBA and the bits [3:0] carry the 4-bit sub-block of HGF. The standard 8b/10b data tables apply, for example D0.0 at negative disparity is 10'h274 and D21.5 is 10'h2AA.
- R4: Every code group has 4, 5 or 6 ones. rd_pos_o (1 = positive) inverts after a group with 4 or 6 ones and is unchanged after a group with 5 ones.
- R5: When the running disparity is negative, no emitted sub-block has more zeros than ones, so a non-neutral group has 6 ones. When the running disparity is positive, the mirror rule applies.
- R6: For y = 7, the alternate 4-bit form (0111 at negative, 1000 at positive) is used when x is 17, 18 or 20 and the disparity after the 6-bit sub-block is negative. It is also used when x is 11, 13 or 14 and that disparity is positive. All other y = 7 data characters use 1110/0001. D17.7 at negative disparity is 10'h237.
- R7: With in_k=1 exactly twelve characters are legal: K28.0 to K28.7, and K23.7, K27.7, K29.7 and K30.7. K28.5 is 10'h0FA at negative and 10'h305 at positive disparity. For legal control characters kerr_o is 0.
- R8: When in_k=1 on an illegal control byte, kerr_o=1 for that group, and code_o and the disparity are those of the data character with the same byte value.
- R9: No code group holds six identical consecutive bits. A run of five identical bits appears only in the 6-bit sub-block 001111/110000, which is the comma sub-block K28.1, K28.5 and K28.7 use. Across consecutive groups the line run stays at 5 or less.
- R10: In cycles without a load, rd_pos_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Load strobe for in_byte and in_k |
| in_byte | input | 8 | Byte HGF EDCBA, bit 0 = A |
| in_k | input | 1 | Requests a control character |
| code_o | output | 10 | Code group abcdei fghj, bit 9 = a |
| code_vld_o | output | 1 | code_o holds a group loaded on the previous edge |
| rd_pos_o | output | 1 | Running disparity after the last group, 1 = positive |
| kerr_o | output | 1 | The last group was requested as an illegal control character |

## Verification
The hardest case to reach from the ports is a positive running disparity at the 4-bit sub-block in front of one of the x values that select the alternate y = 7 form. Most bytes arrive at that point with whatever disparity the previous traffic happened to leave. Before every byte, the bench therefore steers the disparity to a chosen sign by inserting K28.5, which always flips it. It then sweeps all 256 data values at both signs, all twelve control characters at both signs, and a set of illegal control requests. The scoreboard also checks run length across the joints between consecutive groups.

// File: rtl/line_enc_pkg.sv
package line_enc_pkg;
    localparam int BYTE_W = 8;
    localparam int X_W    = 5;
    localparam int Y_W    = 3;
    localparam int SUB6_W = 6;
    localparam int SUB4_W = 4;
    localparam int CODE_W = SUB6_W + SUB4_W;

    typedef enum logic {
        RD_NEG = 1'b0,
        RD_POS = 1'b1
    } rd_state_t;

    // control characters that may be sent with the control flag
    function automatic logic legal_ctrl(input logic [X_W-1:0] x, input logic [Y_W-1:0] y);
        return (x == 5'd28) ||
               ((y == 3'd7) && ((x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30)));
    endfunction
endpackage

// File: rtl/lenc_class6.sv
module lenc_class6
    import line_enc_pkg::*;
(
    input  logic [X_W-1:0]    x,
    input  logic              k28,
    output logic [SUB6_W-1:0] prim,
    output logic              alt
);
    logic [SUB6_W-1:0] dtab;

    always_comb begin
        unique case (x)
            5'd0:  dtab = 6'b100111;
            5'd1:  dtab = 6'b011101;
            5'd2:  dtab = 6'b101101;
            5'd3:  dtab = 6'b110001;
            5'd4:  dtab = 6'b110101;
            5'd5:  dtab = 6'b101001;
            5'd6:  dtab = 6'b011001;
            5'd7:  dtab = 6'b111000;
            5'd8:  dtab = 6'b111001;
            5'd9:  dtab = 6'b100101;
            5'd10: dtab = 6'b010101;
            5'd11: dtab = 6'b110100;
            5'd12: dtab = 6'b001101;
            5'd13: dtab = 6'b101100;
            5'd14: dtab = 6'b011100;
            5'd15: dtab = 6'b010111;
            5'd16: dtab = 6'b011011;
            5'd17: dtab = 6'b100011;
            5'd18: dtab = 6'b010011;
            5'd19: dtab = 6'b110010;
            5'd20: dtab = 6'b001011;
            5'd21: dtab = 6'b101010;
            5'd22: dtab = 6'b011010;
            5'd23: dtab = 6'b111010;
            5'd24: dtab = 6'b110011;
            5'd25: dtab = 6'b100110;
            5'd26: dtab = 6'b010110;
            5'd27: dtab = 6'b110110;
            5'd28: dtab = 6'b001110;
            5'd29: dtab = 6'b101110;
            5'd30: dtab = 6'b011110;
            default: dtab = 6'b101011;
        endcase
    end

    // classification: unbalanced forms and the D.07 pair alternate
    always_comb begin
        if (k28) begin
            prim = 6'b001111;
            alt  = 1'b1;
        end else begin
            prim = dtab;
            alt  = ($countones(dtab) != SUB6_W / 2) || (x == 5'd7);
        end
    end
endmodule

// File: rtl/lenc_class4.sv
module lenc_class4
    import line_enc_pkg::*;
(
    input  logic [X_W-1:0]    x,
    input  logic [Y_W-1:0]    y,
    input  logic              kmode,
    input  logic              rd_mid,
    output logic [SUB4_W-1:0] prim,
    output logic              alt
);
    logic use_a7;

    always_comb begin
        use_a7 = (!rd_mid && ((x == 5'd17) || (x == 5'd18) || (x == 5'd20))) ||
                 ( rd_mid && ((x == 5'd11) || (x == 5'd13) || (x == 5'd14)));
        if (kmode) begin
            alt = 1'b1;
            unique case (y)
                3'd0: prim = 4'b1011;
                3'd1: prim = 4'b0110;
                3'd2: prim = 4'b1010;
                3'd3: prim = 4'b1100;
                3'd4: prim = 4'b1101;
                3'd5: prim = 4'b0101;
                3'd6: prim = 4'b1001;
                default: prim = 4'b0111;
            endcase
        end else begin
            alt = (y == 3'd0) || (y == 3'd3) || (y == 3'd4) || (y == 3'd7);
            unique case (y)
                3'd0: prim = 4'b1011;
                3'd1: prim = 4'b1001;
                3'd2: prim = 4'b0101;
                3'd3: prim = 4'b1100;
                3'd4: prim = 4'b1101;
                3'd5: prim = 4'b1010;
                3'd6: prim = 4'b0110;
                default: prim = use_a7 ? 4'b0111 : 4'b1110;
            endcase
        end
    end
endmodule

// File: rtl/lenc_cmpl.sv
module lenc_cmpl #(
    parameter int W = 6
) (
    input  logic [W-1:0] prim,
    input  logic         alt,
    input  logic         rd_in,
    output logic [W-1:0] code,
    output logic         rd_out
);
    always_comb begin
        code   = (rd_in && alt) ? ~prim : prim;
        rd_out = ($countones(code) == W / 2) ? rd_in : ~rd_in;
    end
endmodule

// File: rtl/line_enc8b10b.sv
module line_enc8b10b
    import line_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_k,
    output logic [CODE_W-1:0] code_o,
    output logic              code_vld_o,
    output logic              rd_pos_o,
    output logic              kerr_o
);
    rd_state_t         rd_q, rd_nxt;
    logic [X_W-1:0]    x;
    logic [Y_W-1:0]    y;
    logic              legal, keff, flip;
    logic              rd_cur, rd_mid, rd_end;
    logic [SUB6_W-1:0] p6, c6;
    logic [SUB4_W-1:0] p4, c4;
    logic              a6, a4;

    assign x      = in_byte[X_W-1:0];
    assign y      = in_byte[BYTE_W-1:X_W];
    assign legal  = legal_ctrl(x, y);
    assign keff   = in_k && legal;
    assign rd_cur = (rd_q == RD_POS);

    lenc_class6 u_cl6 (.x(x), .k28(keff && (x == 5'd28)), .prim(p6), .alt(a6));
    lenc_cmpl #(.W(SUB6_W)) u_cm6 (.prim(p6), .alt(a6), .rd_in(rd_cur), .code(c6), .rd_out(rd_mid));
    lenc_class4 u_cl4 (.x(x), .y(y), .kmode(keff), .rd_mid(rd_mid), .prim(p4), .alt(a4));
    lenc_cmpl #(.W(SUB4_W)) u_cm4 (.prim(p4), .alt(a4), .rd_in(rd_mid), .code(c4), .rd_out(rd_end));

    assign flip = in_vld && (rd_end != rd_cur);

    // transitions HOLD / FLIP
    always_comb begin
        rd_nxt = rd_q;
        unique case (rd_q)
            RD_NEG: if (flip) rd_nxt = RD_POS;
            RD_POS: if (flip) rd_nxt = RD_NEG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= RD_NEG;
        else        rd_q <= rd_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o     <= '0;
            code_vld_o <= 1'b0;
            kerr_o     <= 1'b0;
        end else begin
            code_vld_o <= in_vld;
            kerr_o     <= in_vld && in_k && !legal;
            if (in_vld) code_o <= {c6, c4};
        end
    end

    assign rd_pos_o = (rd_q == RD_POS);
endmodule

// File: rtl/line_enc8b10b_chk.sv
module line_enc8b10b_chk
    import line_enc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code_o,
    input logic              code_vld_o,
    input logic              rd_pos_o,
    input logic              kerr_o
);
    function automatic logic has_run(input logic [CODE_W-1:0] c, input int n);
        logic r;
        r = 1'b0;
        for (int i = 0; i + n <= CODE_W; i++) begin
            logic all1, all0;
            all1 = 1'b1;
            all0 = 1'b1;
            for (int j = 0; j < n; j++) begin
                all1 = all1 & c[i+j];
                all0 = all0 & ~c[i+j];
            end
            r = r | all1 | all0;
        end
        return r;
    endfunction

    // R4
    disp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld_o |-> ($countones(code_o) >= 4 && $countones(code_o) <= 6));

    // R4
    rd_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld_o |-> (($countones(code_o) == 5) == (rd_pos_o == $past(rd_pos_o))));

    // R5
    rd_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld_o && !$past(rd_pos_o) && $countones(code_o) != 5) |-> ($countones(code_o) == 6));

    // R9
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld_o |-> !has_run(code_o, 6));

    // R9
    comma_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld_o && has_run(code_o, 5)) |-> (code_o[9:4] == 6'b001111 || code_o[9:4] == 6'b110000));

    // R8
    kerr_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kerr_o |-> code_vld_o);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_vld_o |-> $stable(rd_pos_o));
endmodule

bind line_enc8b10b line_enc8b10b_chk u_chk (
    .clk(clk), .rst_n(rst_n), .code_o(code_o), .code_vld_o(code_vld_o),
    .rd_pos_o(rd_pos_o), .kerr_o(kerr_o)
);

// File: tb/test_line_enc8b10b.sv
module test_line_enc8b10b;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_k = 1'b0;
    logic [9:0] code_o;
    logic       code_vld_o, rd_pos_o, kerr_o;

    int n_chk = 0;
    int n_fail = 0;
    bit m_rd = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [9:0] code;
        bit         rd;
        bit         kerr;
        string      tag;
    } exp_t;
    exp_t sb[$];
    logic [9:0] last_code;
    bit         have_last = 1'b0;

    always #10 clk = ~clk;

    line_enc8b10b i_line_enc8b10b (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte), .in_k(in_k),
        .code_o(code_o), .code_vld_o(code_vld_o), .rd_pos_o(rd_pos_o), .kerr_o(kerr_o)
    );

    function automatic logic [5:0] m6(input logic [4:0] x);
        case (x)
            0: return 6'b100111;  1: return 6'b011101;  2: return 6'b101101;  3: return 6'b110001;
            4: return 6'b110101;  5: return 6'b101001;  6: return 6'b011001;  7: return 6'b111000;
            8: return 6'b111001;  9: return 6'b100101; 10: return 6'b010101; 11: return 6'b110100;
           12: return 6'b001101; 13: return 6'b101100; 14: return 6'b011100; 15: return 6'b010111;
           16: return 6'b011011; 17: return 6'b100011; 18: return 6'b010011; 19: return 6'b110010;
           20: return 6'b001011; 21: return 6'b101010; 22: return 6'b011010; 23: return 6'b111010;
           24: return 6'b110011; 25: return 6'b100110; 26: return 6'b010110; 27: return 6'b110110;
           28: return 6'b001110; 29: return 6'b101110; 30: return 6'b011110; default: return 6'b101011;
        endcase
    endfunction

    function automatic logic [3:0] m4d(input logic [2:0] y);
        case (y)
            0: return 4'b1011; 1: return 4'b1001; 2: return 4'b0101; 3: return 4'b1100;
            4: return 4'b1101; 5: return 4'b1010; 6: return 4'b0110; default: return 4'b1110;
        endcase
    endfunction

    function automatic logic [3:0] m4k(input logic [2:0] y);
        case (y)
            0: return 4'b1011; 1: return 4'b0110; 2: return 4'b1010; 3: return 4'b1100;
            4: return 4'b1101; 5: return 4'b0101; 6: return 4'b1001; default: return 4'b0111;
        endcase
    endfunction

    task automatic model(input logic [7:0] b, input bit k, input bit rd,
                         output logic [9:0] code, output bit rd_o, output bit ke);
        logic [4:0] x;
        logic [2:0] y;
        logic [5:0] s6;
        logic [3:0] s4;
        bit lg, r1;
        x  = b[4:0];
        y  = b[7:5];
        lg = k && (x == 28 || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30)));
        ke = k && !lg;
        s6 = (lg && x == 28) ? 6'b001111 : m6(x);
        if (rd && ($countones(s6) != 3 || x == 7)) s6 = ~s6;
        r1 = ($countones(s6) == 3) ? rd : !rd;
        if (lg) begin
            s4 = m4k(y);
            if (r1) s4 = ~s4;
        end else begin
            s4 = m4d(y);
            if (y == 7 && ((!r1 && (x == 17 || x == 18 || x == 20)) ||
                           ( r1 && (x == 11 || x == 13 || x == 14)))) s4 = 4'b0111;
            if (r1 && (y == 0 || y == 3 || y == 4 || y == 7)) s4 = ~s4;
        end
        rd_o = ($countones(s4) == 2) ? r1 : !r1;
        code = {s6, s4};
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: called at a falling edge, returns at the next falling edge
    task automatic send(input logic [7:0] b, input bit k, input string tag);
        exp_t e;
        model(b, k, m_rd, e.code, e.rd, e.kerr);
        e.tag = tag;
        sb.push_back(e);
        m_rd    = e.rd;
        in_byte = b;
        in_k    = k;
        in_vld  = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        check(code_vld_o === 1'b1, "R2", "code_vld_o after load", 32'(code_vld_o), 1);
    endtask

    task automatic steer(input bit target);
        if (m_rd != target) send({3'd5, 5'd28}, 1'b1, "R7");
    endtask

    function automatic bit joint_ok(input logic [9:0] a, input logic [9:0] b);
        logic [19:0] s;
        s = {a, b};
        for (int i = 0; i + 6 <= 20; i++)
            if (s[i+:6] == 6'h3F || s[i+:6] == 6'h00) return 1'b0;
        return 1'b1;
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && code_vld_o && !done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected group", 32'(code_o), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(code_o === e.code, e.tag, "code_o", 32'(code_o), 32'(e.code));
                check(rd_pos_o === e.rd, "R4", "rd_pos_o", 32'(rd_pos_o), 32'(e.rd));
                check(kerr_o === e.kerr, "R8", "kerr_o", 32'(kerr_o), 32'(e.kerr));
                if (have_last)
                    check(joint_ok(last_code, code_o), "R9", "line run", 32'(code_o), 32'(last_code));
                last_code = code_o;
                have_last = 1'b1;
            end
        end
    end

    task automatic finish_test();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
        finish_test();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rd_pos_o === 1'b0, "R1", "rd in reset", 32'(rd_pos_o), 0);
        check(code_vld_o === 1'b0, "R1", "vld in reset", 32'(code_vld_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_pos_o === 1'b0, "R1", "rd after reset", 32'(rd_pos_o), 0);
        check(code_vld_o === 1'b0, "R1", "vld after reset", 32'(code_vld_o), 0);

        // fixed values
        send({3'd5, 5'd28}, 1'b1, "R7");
        check(code_o === 10'h0FA, "R7", "K28.5 neg", 32'(code_o), 32'h0FA);
        send({3'd5, 5'd28}, 1'b1, "R7");
        check(code_o === 10'h305, "R7", "K28.5 pos", 32'(code_o), 32'h305);
        send(8'h00, 1'b0, "R3");
        check(code_o === 10'h274, "R3", "D0.0 neg", 32'(code_o), 32'h274);
        send({3'd5, 5'd21}, 1'b0, "R3");
        check(code_o === 10'h2AA, "R3", "D21.5", 32'(code_o), 32'h2AA);
        steer(1'b0);
        send({3'd7, 5'd17}, 1'b0, "R6");
        check(code_o === 10'h237, "R6", "D17.7 neg", 32'(code_o), 32'h237);

        // idle cycles leave disparity unchanged
        repeat (4) begin
            @(negedge clk);
            check(code_vld_o === 1'b0, "R2", "vld idle", 32'(code_vld_o), 0);
            check(rd_pos_o === m_rd, "R10", "rd idle", 32'(rd_pos_o), 32'(m_rd));
        end

        // all data bytes at both disparities
        for (int b = 0; b < 256; b++) begin
            for (int t = 0; t < 2; t++) begin
                steer(t[0]);
                send(8'(b), 1'b0, (b[7:5] == 3'd7) ? "R6" : "R3");
            end
        end

        // legal control characters at both disparities
        for (int t = 0; t < 2; t++) begin
            for (int y = 0; y < 8; y++) begin
                steer(t[0]);
                send({3'(y), 5'd28}, 1'b1, "R7");
                check(kerr_o === 1'b0, "R7", "kerr legal", 32'(kerr_o), 0);
            end
            steer(t[0]); send({3'd7, 5'd23}, 1'b1, "R7");
            steer(t[0]); send({3'd7, 5'd27}, 1'b1, "R7");
            steer(t[0]); send({3'd7, 5'd29}, 1'b1, "R7");
            steer(t[0]); send({3'd7, 5'd30}, 1'b1, "R7");
        end

        // illegal control requests, back to back
        send({3'd0, 5'd5}, 1'b1, "R8");
        check(kerr_o === 1'b1, "R8", "kerr illegal", 32'(kerr_o), 1);
        send({3'd3, 5'd23}, 1'b1, "R8");
        send({3'd7, 5'd31}, 1'b1, "R8");
        send({3'd6, 5'd27}, 1'b1, "R8");
        send({3'd7, 5'd11}, 1'b1, "R8");
        send({3'd7, 5'd13}, 1'b0, "R6");
        send({3'd7, 5'd14}, 1'b1, "R8");

        @(negedge clk);
        check(sb.size() == 0, "R2", "scoreboard drained", 32'(sb.size()), 0);
        check(rd_pos_o === m_rd, "R10", "rd final", 32'(rd_pos_o), 32'(m_rd));
        finish_test();
    end
endmodule